// File: doc/BRIEF.md
# Temperature Compensation Cycle Controller

This block decides when a real-time clock oscillator runs a temperature-compensation cycle and holds the resulting frequency-correction word. A host reaches a small register window through a byte-wide register port. The control byte at address 0Dh carries a master enable, a two-bit battery-mode field and a five-bit factory trim field. The factory trim field is fixed at reset and cannot be overwritten. Two trim bytes at 0Bh and 0Ch are read-only.

A one-clock 1 Hz tick drives the schedule. With main supply present and the block enabled, a cycle starts every 60 seconds. On battery, the battery-mode field picks the interval or stops compensation altogether. A host write that sets the enable bit starts a cycle at once and restarts the interval count. Each cycle waits for a temperature sample from the sensor. The correction word changes only when that sample differs from the one captured at the previous conversion.

Top module: `tcomp_ctrl`

## Requirements
- R1: After reset, address 0Dh reads FACTORY_TRIM in bits 4:0 with bits 7:5 at zero, `corr_out` is zero, and `busy`, `cycle_start` and `cycle_done` are low.
- R2: Writes to 0Dh leave bits 4:0 at FACTORY_TRIM. Bits 7:5 read back exactly as last written: bit 7 is the enable, and bits 6:5 are the battery mode.
- R3: Address 0Bh always reads TRIM_B_VAL and address 0Ch always reads TRIM_C_VAL, whatever has been written to them. Every other address except 0Dh reads zero.
- R4: A write to 0Dh with bit 7 set, made while no cycle is running, raises `cycle_start` in the clock after the write edge. It also restarts the seconds count from zero.
- R5: With enable set and `main_ok` high, a cycle starts on every 60th tick counted from the last restart, whatever the battery-mode field holds.
- R6: With enable set and `main_ok` low, the battery mode sets the interval: 00 starts no scheduled cycles, 01 gives 60 ticks, 10 gives 120 ticks and 11 gives 600 ticks.
- R7: A running cycle ends on the first `temp_vld`, with a one-clock `cycle_done` pulse. `corr_out` is loaded only when that sample differs from the previously captured sample, or when it is the first conversion since reset. The loaded value is temp + trim, plus 40h when `main_ok` is low, taken modulo 2^TEMP_W.
- R8: A trigger that arrives while a cycle is running does not restart that cycle. It is held, and a new cycle starts in the clock after that cycle's `cycle_done`.
- R9: With the enable bit cleared, no scheduled cycle starts, and `corr_out` keeps its last value.
- R10: `cycle_start` lasts one clock. `busy` is high from `cycle_start` until the clock of `cycle_done`, and it is low in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one clock per byte |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| tick_1hz | input | 1 | One-clock pulse once per second |
| main_ok | input | 1 | High while the main supply is present |
| temp | input | TEMP_W | Temperature sample |
| temp_vld | input | 1 | Sample strobe that ends a running cycle |
| cycle_start | output | 1 | One-clock pulse when a cycle begins |
| cycle_done | output | 1 | One-clock pulse when a cycle ends |
| busy | output | 1 | A cycle is in progress |
| corr_out | output | TEMP_W | Frequency-correction word |

## Verification
The schedule is driven by runs of ticks that stop one short of each interval and then add one more tick. This separates the 60, 120 and 600 second intervals, shows that the main supply overrides the battery-mode field, and checks that a write restarts the count. Conversions alternate between a repeated sample taken under a changed supply state and a new sample. Because the correction formula depends on the supply state, a word that is reloaded wrongly shows up at the output. A trigger issued while a cycle is running shows whether it is held as pending or restarts the cycle.

// File: rtl/tcomp_pkg.sv
package tcomp_pkg;

    localparam logic [7:0] ADDR_TRIM_B = 8'h0B;
    localparam logic [7:0] ADDR_TRIM_C = 8'h0C;
    localparam logic [7:0] ADDR_CTRL   = 8'h0D;
    localparam int         BATT_OFFSET = 8'h40;

    typedef enum logic [1:0] {
        BAT_OFF  = 2'b00,
        BAT_X1   = 2'b01,
        BAT_X2   = 2'b10,
        BAT_X10  = 2'b11
    } bat_mode_e;

    typedef struct packed {
        logic      en;
        bat_mode_e bat;
        logic [4:0] trim;
    } ctrl_reg_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } cyc_state_e;

    // Interval in seconds for the present supply state; zero means no schedule.
    function automatic int unsigned period_sec(input logic on_main,
                                               input bat_mode_e bat,
                                               input int unsigned base);
        if (on_main) return base;
        case (bat)
            BAT_X1:  return base;
            BAT_X2:  return base * 2;
            BAT_X10: return base * 10;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/tcomp_regs.sv
module tcomp_regs
    import tcomp_pkg::*;
#(
    parameter logic [4:0] FACTORY_TRIM = 5'h13,
    parameter logic [7:0] TRIM_B_VAL   = 8'hA5,
    parameter logic [7:0] TRIM_C_VAL   = 8'h3C
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    input  logic       wr,
    output logic [7:0] rdata,
    output ctrl_reg_t  ctrl,
    output logic       wr_trig
);

    logic      en_q;
    bat_mode_e bat_q;
    logic      ctrl_wr;

    assign ctrl_wr = wr && (addr == ADDR_CTRL);
    assign wr_trig = ctrl_wr && wdata[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            bat_q <= BAT_OFF;
        end else if (ctrl_wr) begin
            en_q  <= wdata[7];
            bat_q <= bat_mode_e'(wdata[6:5]);
        end
    end

    assign ctrl = '{en: en_q, bat: bat_q, trim: FACTORY_TRIM};

    always_comb begin
        case (addr)
            ADDR_CTRL:   rdata = ctrl;
            ADDR_TRIM_B: rdata = TRIM_B_VAL;
            ADDR_TRIM_C: rdata = TRIM_C_VAL;
            default:     rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/tcomp_sched.sv
module tcomp_sched
    import tcomp_pkg::*;
#(
    parameter int unsigned BASE_SEC = 60
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      en,
    input  logic      main_ok,
    input  bat_mode_e bat,
    input  logic      restart,
    output logic      fire
);

    localparam int unsigned MAX_P = BASE_SEC * 10;
    localparam int          CNT_W = $clog2(MAX_P + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic             active;

    always_comb begin
        int unsigned per;
        per    = period_sec(main_ok, bat, BASE_SEC);
        active = en && (per != 0);
        last   = (per != 0) ? CNT_W'(per - 1) : '0;
    end

    assign fire = active && tick && (cnt >= last);

    always_ff @(posedge clk) begin
        if (rst || !en || restart) begin
            cnt <= '0;
        end else if (tick) begin
            if (fire || !active) cnt <= '0;
            else                 cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/tcomp_cycle.sv
module tcomp_cycle
    import tcomp_pkg::*;
#(
    parameter int TEMP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  logic [TEMP_W-1:0] temp,
    input  logic              temp_vld,
    input  logic [4:0]        trim,
    input  logic              on_batt,
    output logic              start,
    output logic              done,
    output logic              busy,
    output logic [TEMP_W-1:0] corr
);

    cyc_state_e        st;
    logic              pend;
    logic              have_last;
    logic [TEMP_W-1:0] last_temp;
    logic [TEMP_W-1:0] corr_calc;

    assign corr_calc = temp + TEMP_W'(trim)
                     + (on_batt ? TEMP_W'(BATT_OFFSET) : TEMP_W'(0));
    assign busy = (st == ST_CONV);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            pend      <= 1'b0;
            have_last <= 1'b0;
            last_temp <= '0;
            corr      <= '0;
            start     <= 1'b0;
            done      <= 1'b0;
        end else begin
            start <= 1'b0;
            done  <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (trig || pend) begin
                        st    <= ST_CONV;
                        start <= 1'b1;
                        pend  <= 1'b0;
                    end
                end
                ST_CONV: begin
                    if (trig) pend <= 1'b1;
                    if (temp_vld) begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                        if (!have_last || temp != last_temp) begin
                            corr      <= corr_calc;
                            last_temp <= temp;
                            have_last <= 1'b1;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tcomp_ctrl.sv
module tcomp_ctrl
    import tcomp_pkg::*;
#(
    parameter logic [4:0]  FACTORY_TRIM = 5'h13,
    parameter logic [7:0]  TRIM_B_VAL   = 8'hA5,
    parameter logic [7:0]  TRIM_C_VAL   = 8'h3C,
    parameter int unsigned BASE_SEC     = 60,
    parameter int          TEMP_W       = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              reg_wr,
    output logic [7:0]        reg_rdata,
    input  logic              tick_1hz,
    input  logic              main_ok,
    input  logic [TEMP_W-1:0] temp,
    input  logic              temp_vld,
    output logic              cycle_start,
    output logic              cycle_done,
    output logic              busy,
    output logic [TEMP_W-1:0] corr_out
);

    ctrl_reg_t ctrl;
    logic      wr_trig;
    logic      sched_fire;

    tcomp_regs #(
        .FACTORY_TRIM(FACTORY_TRIM),
        .TRIM_B_VAL  (TRIM_B_VAL),
        .TRIM_C_VAL  (TRIM_C_VAL)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .wr     (reg_wr),
        .rdata  (reg_rdata),
        .ctrl   (ctrl),
        .wr_trig(wr_trig)
    );

    tcomp_sched #(.BASE_SEC(BASE_SEC)) u_sched (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_1hz),
        .en     (ctrl.en),
        .main_ok(main_ok),
        .bat    (ctrl.bat),
        .restart(wr_trig),
        .fire   (sched_fire)
    );

    tcomp_cycle #(.TEMP_W(TEMP_W)) u_cycle (
        .clk     (clk),
        .rst     (rst),
        .trig    (wr_trig || sched_fire),
        .temp    (temp),
        .temp_vld(temp_vld),
        .trim    (ctrl.trim),
        .on_batt (!main_ok),
        .start   (cycle_start),
        .done    (cycle_done),
        .busy    (busy),
        .corr    (corr_out)
    );

endmodule

// File: rtl/tcomp_ctrl_chk.sv
module tcomp_ctrl_chk #(
    parameter logic [4:0] FACTORY_TRIM = 5'h13,
    parameter int         TEMP_W       = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        reg_addr,
    input logic [7:0]        reg_wdata,
    input logic              reg_wr,
    input logic [7:0]        reg_rdata,
    input logic              cycle_start,
    input logic              cycle_done,
    input logic              busy,
    input logic [TEMP_W-1:0] corr_out
);

    assert_trim_locked_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 8'h0D) |-> (reg_rdata[4:0] == FACTORY_TRIM));

    assert_write_starts_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 8'h0D && reg_wdata[7] && !busy) |=> cycle_start);

    assert_corr_on_done_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(corr_out) |-> cycle_done);

    assert_start_single_R10: assert property (@(posedge clk) disable iff (rst)
        cycle_start |=> !cycle_start);

    assert_start_busy_R10: assert property (@(posedge clk) disable iff (rst)
        cycle_start |-> busy);

    assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (rst)
        cycle_done |-> (!busy && $past(busy)));

endmodule

bind tcomp_ctrl tcomp_ctrl_chk #(
    .FACTORY_TRIM(FACTORY_TRIM),
    .TEMP_W      (TEMP_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_wr     (reg_wr),
    .reg_rdata  (reg_rdata),
    .cycle_start(cycle_start),
    .cycle_done (cycle_done),
    .busy       (busy),
    .corr_out   (corr_out)
);

// File: tb/tcomp_ctrl_test.sv
module tcomp_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_rdata;
    logic       tick_1hz = 1'b0;
    logic       main_ok = 1'b1;
    logic [7:0] temp = 8'h00;
    logic       man_vld = 1'b0;
    logic       auto_vld = 1'b0;
    logic       auto_sense = 1'b0;
    logic       cycle_start, cycle_done, busy;
    logic [7:0] corr_out;

    int tests = 0;
    int fails = 0;
    int starts = 0;

    always #10 clk = ~clk;

    tcomp_ctrl uut (
        .clk        (clk),
        .rst        (rst),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_wr     (reg_wr),
        .reg_rdata  (reg_rdata),
        .tick_1hz   (tick_1hz),
        .main_ok    (main_ok),
        .temp       (temp),
        .temp_vld   (man_vld | auto_vld),
        .cycle_start(cycle_start),
        .cycle_done (cycle_done),
        .busy       (busy),
        .corr_out   (corr_out)
    );

    always @(negedge clk) if (cycle_start) starts++;

    always @(negedge clk) begin
        if (auto_sense && busy && !auto_vld) auto_vld = 1'b1;
        else                                 auto_vld = 1'b0;
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_1hz = 1'b1;
            @(negedge clk) tick_1hz = 1'b0;
        end
    endtask

    task automatic sample(input logic [7:0] t);
        @(negedge clk);
        temp = t; man_vld = 1'b1;
        @(negedge clk);
        man_vld = 1'b0;
    endtask

    task automatic test_reset();
        logic [7:0] d;
        reg_read(8'h0D, d);  chk("R1 ctrl reset", d, 8'h13);
        chk("R1 corr reset", corr_out, 0);
        chk("R1 busy reset", {busy, cycle_start, cycle_done}, 0);
        reg_read(8'h0B, d);  chk("R3 read 0Bh", d, 8'hA5);
        reg_read(8'h0C, d);  chk("R3 read 0Ch", d, 8'h3C);
        reg_read(8'h00, d);  chk("R3 unmapped", d, 0);
    endtask

    task automatic test_lock();
        logic [7:0] d;
        int s0 = starts;
        reg_write(8'h0D, 8'h6A);
        reg_read(8'h0D, d);  chk("R2 lock low bits", d, 8'h73);
        reg_write(8'h0B, 8'hFF);
        reg_write(8'h0C, 8'h00);
        reg_read(8'h0B, d);  chk("R3 0Bh ignores write", d, 8'hA5);
        reg_read(8'h0C, d);  chk("R3 0Ch ignores write", d, 8'h3C);
        idle(2);
        chk("R4 no start with bit7 clear", starts, s0);
    endtask

    task automatic test_immediate();
        reg_write(8'h0D, 8'h80);
        chk("R4 start after write", cycle_start, 1);
        chk("R10 busy at start", busy, 1);
        idle(1);
        chk("R10 start one clock", cycle_start, 0);
        chk("R10 busy held", busy, 1);
        sample(8'h20);
        chk("R7 done pulse", cycle_done, 1);
        chk("R10 busy low at done", busy, 0);
        chk("R7 first conversion loads", corr_out, 8'h33);
    endtask

    task automatic test_change();
        main_ok = 1'b0;
        reg_write(8'h0D, 8'h80);
        sample(8'h20);
        chk("R7 done same temp", cycle_done, 1);
        chk("R7 same temp keeps corr", corr_out, 8'h33);
        reg_write(8'h0D, 8'h80);
        sample(8'h21);
        chk("R7 new temp loads corr", corr_out, 8'h74);
        main_ok = 1'b1;
    endtask

    task automatic test_pending();
        reg_write(8'h0D, 8'h80);
        idle(1);
        reg_write(8'h0D, 8'h80);
        chk("R8 no restart while busy", cycle_start, 0);
        chk("R8 still busy", busy, 1);
        sample(8'h21);
        chk("R8 done first", {cycle_done, cycle_start}, 2'b10);
        idle(1);
        chk("R8 pending start", cycle_start, 1);
        sample(8'h21);
        chk("R8 pending cycle done", cycle_done, 1);
        chk("R7 corr kept", corr_out, 8'h74);
    endtask

    task automatic interval(input string req, input logic [7:0] cw, input int per);
        int s;
        reg_write(8'h0D, cw);
        idle(4);
        s = starts;
        ticks(per - 1);
        idle(2);
        chk({req, " none before interval"}, starts, s);
        ticks(1);
        idle(3);
        chk({req, " start at interval"}, starts, s + 1);
    endtask

    task automatic test_periodic();
        int s;
        auto_sense = 1'b1;
        main_ok = 1'b1;
        interval("R5 main 60", 8'h80, 60);
        interval("R5 main ignores mode", 8'hE0, 60);
        ticks(30);
        reg_write(8'h0D, 8'h80);
        idle(4);
        s = starts;
        ticks(59);
        idle(2);
        chk("R4 restart count", starts, s);
        ticks(1);
        idle(3);
        chk("R4 fire after restart", starts, s + 1);
    endtask

    task automatic test_battery();
        int s;
        main_ok = 1'b0;
        interval("R6 mode01", 8'hA0, 60);
        interval("R6 mode10", 8'hC0, 120);
        interval("R6 mode11", 8'hE0, 600);
        reg_write(8'h0D, 8'h80);
        idle(4);
        s = starts;
        ticks(700);
        idle(3);
        chk("R6 mode00 no cycles", starts, s);
        main_ok = 1'b1;
    endtask

    task automatic test_disable();
        int s;
        logic [7:0] c;
        reg_write(8'h0D, 8'h00);
        idle(4);
        s = starts;
        c = corr_out;
        ticks(700);
        idle(3);
        chk("R9 no cycles disabled", starts, s);
        chk("R9 corr kept", corr_out, c);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hang expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(1);
        test_reset();
        test_lock();
        test_immediate();
        test_change();
        test_pending();
        test_periodic();
        test_battery();
        test_disable();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule